// File: doc/BRIEF.md
# GPIO Interrupt-on-Change Controller

This block raises interrupts for a two-port GPIO expander with 8 pins per port. It samples the input values of both ports through a synchronizer. On each sampled change it decides, pin by pin, whether to set an interrupt flag. A pin can be set to flag any change from its previously stored value, or to flag a mismatch against a default value. The first flag on a port also captures that port's input value.

Configuration arrives as plain register values from a neighbouring register block: pin direction, interrupt enable, compare mode, default value, a polarity bit and a mirror bit. That register block sends a one-cycle clear pulse per port whenever software reads that port's GPIO value or its capture value. The block drives one interrupt line per port. The two lines can be tied together logically (mirror mode), and their active level is selectable.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, both flag outputs and both capture outputs are 0x00 and both interrupt outputs are 1 (the inactive level with the polarity bit at 0).
- R2: For a pin whose compare-mode bit is 0, an evaluation sets that pin's flag when the new sample differs from the stored previous sample of that pin.
- R3: For a pin whose compare-mode bit is 1, an evaluation sets that pin's flag when the new sample differs from that pin's default-value bit.
- R4: A flag bit can be set only where the pin's enable bit is 1 and its direction bit is 1 (1 = input).
- R5: A port's capture output loads the sampled port value only when that port's flags were all zero before the evaluation and at least one flag is set by it. While flags stay set, later evaluations leave it unchanged.
- R6: A clear pulse for a port sets that port's flags to zero. It also returns that port's interrupt output to the inactive level.
- R7: With the mirror bit at 1, an evaluation that sets an enabled flag on either port drives both interrupt outputs active. A clear pulse on either port drives both outputs inactive.
- R8: The active level of the interrupt outputs is 1 when the polarity bit is 1 and 0 when it is 0. The inactive level is the opposite.
- R9: An evaluation happens only in a cycle where the sampled value of at least one port differs from its stored previous sample. The evaluation replaces the flags of every port with a nonzero enable mask. Configuration changes alone leave flags and captures unchanged.
- R10: An input change shows on the flag, capture and interrupt outputs on the third rising clock edge after it is applied (two synchronizer stages plus one evaluation register).
- R11: When a clear pulse coincides with an evaluation on the same port, the new flags win. The capture treats the old flags as already cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| porta_in | input | 8 | Port A pin values (asynchronous) |
| portb_in | input | 8 | Port B pin values (asynchronous) |
| dir_a | input | 8 | Port A direction, 1 = input |
| dir_b | input | 8 | Port B direction, 1 = input |
| irq_en_a | input | 8 | Port A per-pin interrupt enable |
| irq_en_b | input | 8 | Port B per-pin interrupt enable |
| cmp_mode_a | input | 8 | Port A mode, 1 = compare to default, 0 = change |
| cmp_mode_b | input | 8 | Port B mode, 1 = compare to default, 0 = change |
| defval_a | input | 8 | Port A default values |
| defval_b | input | 8 | Port B default values |
| pol_high | input | 1 | 1 = interrupts active high |
| mirror | input | 1 | 1 = both interrupt outputs follow both ports |
| rd_clear_a | input | 1 | Clear pulse for port A flags |
| rd_clear_b | input | 1 | Clear pulse for port B flags |
| flag_a | output | 8 | Port A interrupt flags |
| flag_b | output | 8 | Port B interrupt flags |
| cap_a | output | 8 | Port A captured value |
| cap_b | output | 8 | Port B captured value |
| irq_a | output | 1 | Port A interrupt line |
| irq_b | output | 1 | Port B interrupt line |

## Verification
A wrong stored previous sample shows as a flag on an unchanged pin, or as a missing flag, on the third edge after the next input change. It is never seen earlier, so every stimulus step is followed by a full settling window before the outputs are compared. A wrong capture or interrupt-state register is visible right away on cap or irq. It may only diverge after a later clear pulse or event, so every step is checked against a bench model, not just the directed cases.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam logic IRQ_RESET_LEVEL = 1'b1;

  function automatic logic irq_level(input logic active, input logic pol_high);
    return active ? pol_high : ~pol_high;
  endfunction
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] samp,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] en,
  input  logic [W-1:0] cmp,
  input  logic [W-1:0] defv,
  input  logic         evt,
  input  logic         rd_clear,
  output logic         chg,
  output logic         raise,
  output logic [W-1:0] flag_q,
  output logic [W-1:0] cap_q
);
  logic [W-1:0] prev_q;
  logic [W-1:0] hit;
  logic [W-1:0] old_eff;
  logic [W-1:0] flag_n;
  logic         eval;

  assign chg     = (samp != prev_q);
  assign hit     = (((samp ^ prev_q) & ~cmp) | ((samp ^ defv) & cmp)) & en & dir;
  assign eval    = evt && (|en);
  assign old_eff = rd_clear ? '0 : flag_q;
  assign raise   = eval && (|hit);

  always_comb begin
    flag_n = flag_q;
    if (eval)          flag_n = hit;
    else if (rd_clear) flag_n = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      flag_q <= '0;
      cap_q  <= '0;
    end else begin
      if (evt) prev_q <= samp;
      flag_q <= flag_n;
      if (eval && (old_eff == '0) && (|hit)) cap_q <= samp;
    end
  end
endmodule

// File: rtl/gpio_irq_out.sv
module gpio_irq_out
  import gpio_irq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic evt,
  input  logic raise_a,
  input  logic raise_b,
  input  logic rd_clear_a,
  input  logic rd_clear_b,
  input  logic mirror,
  input  logic pol_high,
  output logic irq_a,
  output logic irq_b
);
  logic [1:0] act_q;
  logic [1:0] act_n;

  always_comb begin
    act_n = act_q;
    if (evt) begin
      if (mirror) act_n = {2{raise_a | raise_b}};
      else        act_n = {raise_b, raise_a};
    end else begin
      if (rd_clear_a) begin
        act_n[0] = 1'b0;
        if (mirror) act_n[1] = 1'b0;
      end
      if (rd_clear_b) begin
        act_n[1] = 1'b0;
        if (mirror) act_n[0] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= '0;
      irq_a <= IRQ_RESET_LEVEL;
      irq_b <= IRQ_RESET_LEVEL;
    end else begin
      act_q <= act_n;
      irq_a <= irq_level(act_n[0], pol_high);
      irq_b <= irq_level(act_n[1], pol_high);
    end
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] porta_in,
  input  logic [W-1:0] portb_in,
  input  logic [W-1:0] dir_a,
  input  logic [W-1:0] dir_b,
  input  logic [W-1:0] irq_en_a,
  input  logic [W-1:0] irq_en_b,
  input  logic [W-1:0] cmp_mode_a,
  input  logic [W-1:0] cmp_mode_b,
  input  logic [W-1:0] defval_a,
  input  logic [W-1:0] defval_b,
  input  logic         pol_high,
  input  logic         mirror,
  input  logic         rd_clear_a,
  input  logic         rd_clear_b,
  output logic [W-1:0] flag_a,
  output logic [W-1:0] flag_b,
  output logic [W-1:0] cap_a,
  output logic [W-1:0] cap_b,
  output logic         irq_a,
  output logic         irq_b
);
  localparam int NPORT = 2;

  logic [W-1:0] pin_v  [NPORT];
  logic [W-1:0] samp_v [NPORT];
  logic [W-1:0] dir_v  [NPORT];
  logic [W-1:0] en_v   [NPORT];
  logic [W-1:0] cmp_v  [NPORT];
  logic [W-1:0] def_v  [NPORT];
  logic [W-1:0] flag_v [NPORT];
  logic [W-1:0] cap_v  [NPORT];
  logic         clr_v  [NPORT];
  logic         chg_v  [NPORT];
  logic         rse_v  [NPORT];
  logic         evt;

  assign pin_v[0] = porta_in;   assign pin_v[1] = portb_in;
  assign dir_v[0] = dir_a;      assign dir_v[1] = dir_b;
  assign en_v[0]  = irq_en_a;   assign en_v[1]  = irq_en_b;
  assign cmp_v[0] = cmp_mode_a; assign cmp_v[1] = cmp_mode_b;
  assign def_v[0] = defval_a;   assign def_v[1] = defval_b;
  assign clr_v[0] = rd_clear_a; assign clr_v[1] = rd_clear_b;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    gpio_irq_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (pin_v[p]),
      .q   (samp_v[p])
    );

    gpio_irq_port #(.W(W)) u_port (
      .clk      (clk),
      .rst      (rst),
      .samp     (samp_v[p]),
      .dir      (dir_v[p]),
      .en       (en_v[p]),
      .cmp      (cmp_v[p]),
      .defv     (def_v[p]),
      .evt      (evt),
      .rd_clear (clr_v[p]),
      .chg      (chg_v[p]),
      .raise    (rse_v[p]),
      .flag_q   (flag_v[p]),
      .cap_q    (cap_v[p])
    );
  end

  assign evt = chg_v[0] | chg_v[1];

  gpio_irq_out u_out (
    .clk        (clk),
    .rst        (rst),
    .evt        (evt),
    .raise_a    (rse_v[0]),
    .raise_b    (rse_v[1]),
    .rd_clear_a (rd_clear_a),
    .rd_clear_b (rd_clear_b),
    .mirror     (mirror),
    .pol_high   (pol_high),
    .irq_a      (irq_a),
    .irq_b      (irq_b)
  );

  assign flag_a = flag_v[0];
  assign flag_b = flag_v[1];
  assign cap_a  = cap_v[0];
  assign cap_b  = cap_v[1];
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         evt,
  input logic [W-1:0] irq_en_a,
  input logic [W-1:0] irq_en_b,
  input logic [W-1:0] dir_a,
  input logic [W-1:0] dir_b,
  input logic         rd_clear_a,
  input logic         rd_clear_b,
  input logic [W-1:0] flag_a,
  input logic [W-1:0] flag_b,
  input logic [W-1:0] cap_a,
  input logic [W-1:0] cap_b,
  input logic         irq_a,
  input logic         irq_b
);
  logic past_ok;
  always_ff @(posedge clk) past_ok <= 1'b1;

  AST_RESET_STATE: assert property (@(posedge clk)
    (past_ok && $past(rst)) |-> (flag_a == '0 && flag_b == '0 && cap_a == '0 && cap_b == '0 && irq_a && irq_b)); // R1

  AST_FLAG_MASK_A: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (flag_a != $past(flag_a)) |-> ((flag_a & ~($past(irq_en_a) & $past(dir_a))) == '0)); // R4

  AST_FLAG_MASK_B: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (flag_b != $past(flag_b)) |-> ((flag_b & ~($past(irq_en_b) & $past(dir_b))) == '0)); // R4

  AST_CAP_HOLD_A: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (flag_a != '0 && !rd_clear_a) |=> $stable(cap_a)); // R5

  AST_CAP_HOLD_B: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (flag_b != '0 && !rd_clear_b) |=> $stable(cap_b)); // R5

  AST_CLEAR_A: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (rd_clear_a && !evt) |=> (flag_a == '0)); // R6

  AST_CLEAR_B: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (rd_clear_b && !evt) |=> (flag_b == '0)); // R6

  AST_NO_EVAL_A: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (!evt && !rd_clear_a) |=> ($stable(flag_a) && $stable(cap_a))); // R9

  AST_NO_EVAL_B: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (!evt && !rd_clear_b) |=> ($stable(flag_b) && $stable(cap_b))); // R9
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.W(W)) u_chk (.*);

// File: tb/gpio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] porta_in = '0, portb_in = '0;
  logic [7:0] dir_a = 8'hFF, dir_b = 8'hFF;
  logic [7:0] irq_en_a = '0, irq_en_b = '0;
  logic [7:0] cmp_mode_a = '0, cmp_mode_b = '0;
  logic [7:0] defval_a = '0, defval_b = '0;
  logic       pol_high = 1'b0, mirror = 1'b0;
  logic       rd_clear_a = 1'b0, rd_clear_b = 1'b0;
  logic [7:0] flag_a, flag_b, cap_a, cap_b;
  logic       irq_a, irq_b;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // bench model state
  logic [7:0] m_prev_a = '0, m_prev_b = '0;
  logic [7:0] m_flag_a = '0, m_flag_b = '0;
  logic [7:0] m_cap_a = '0, m_cap_b = '0;
  logic       m_act_a = 1'b0, m_act_b = 1'b0;

  always #4 clk = ~clk;

  gpio_irq_ctrl u_gpio_irq_ctrl (.*);

  function automatic logic [7:0] hit_of(input logic [7:0] nv, input logic [7:0] pv,
                                        input logic [7:0] cm, input logic [7:0] dv,
                                        input logic [7:0] en, input logic [7:0] dr);
    logic [7:0] h;
    for (int i = 0; i < 8; i++) begin
      if (cm[i]) h[i] = (nv[i] != dv[i]);
      else       h[i] = (nv[i] != pv[i]);
      h[i] = h[i] & en[i] & dr[i];
    end
    return h;
  endfunction

  function automatic logic lvl(input logic act);
    return act ? pol_high : ~pol_high;
  endfunction

  task automatic check8(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check8(tag, "flag_a", flag_a, m_flag_a);
    check8(tag, "flag_b", flag_b, m_flag_b);
    check8(tag, "cap_a", cap_a, m_cap_a);
    check8(tag, "cap_b", cap_b, m_cap_b);
    check8(tag, "irq_a", {7'd0, irq_a}, {7'd0, lvl(m_act_a)});
    check8(tag, "irq_b", {7'd0, irq_b}, {7'd0, lvl(m_act_b)});
  endtask

  // model of one evaluation cycle with optional clear pulses
  task automatic model_step(input logic [7:0] pa, input logic [7:0] pb, input logic ca, input logic cb);
    logic [7:0] ha, hb;
    logic ea, eb, ra, rb;
    if (pa != m_prev_a || pb != m_prev_b) begin
      ha = hit_of(pa, m_prev_a, cmp_mode_a, defval_a, irq_en_a, dir_a);
      hb = hit_of(pb, m_prev_b, cmp_mode_b, defval_b, irq_en_b, dir_b);
      ea = (irq_en_a != 0);
      eb = (irq_en_b != 0);
      if (ea) begin
        if ((ca ? 8'h00 : m_flag_a) == 0 && ha != 0) m_cap_a = pa;
        m_flag_a = ha;
      end else if (ca) m_flag_a = '0;
      if (eb) begin
        if ((cb ? 8'h00 : m_flag_b) == 0 && hb != 0) m_cap_b = pb;
        m_flag_b = hb;
      end else if (cb) m_flag_b = '0;
      ra = ea && (ha != 0);
      rb = eb && (hb != 0);
      if (mirror) begin m_act_a = ra | rb; m_act_b = ra | rb; end
      else        begin m_act_a = ra;      m_act_b = rb;      end
      m_prev_a = pa;
      m_prev_b = pb;
    end else begin
      if (ca) begin m_flag_a = '0; m_act_a = 1'b0; if (mirror) m_act_b = 1'b0; end
      if (cb) begin m_flag_b = '0; m_act_b = 1'b0; if (mirror) m_act_a = 1'b0; end
    end
  endtask

  task automatic apply_in(input logic [7:0] pa, input logic [7:0] pb);
    @(negedge clk);
    porta_in = pa; portb_in = pb;
    repeat (4) @(negedge clk);
    model_step(pa, pb, 1'b0, 1'b0);
  endtask

  task automatic pulse_clear(input logic ca, input logic cb);
    @(negedge clk);
    rd_clear_a = ca; rd_clear_b = cb;
    @(negedge clk);
    rd_clear_a = 1'b0; rd_clear_b = 1'b0;
    @(negedge clk);
    model_step(m_prev_a, m_prev_b, ca, cb);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check8("R1", "flag_a", flag_a, 8'h00);
    check8("R1", "cap_b", cap_b, 8'h00);
    check8("R1", "irqs", {6'd0, irq_b, irq_a}, 8'h03);

    irq_en_a = 8'hFF; irq_en_b = 8'hFF;
    // R10 latency: new flags on the third edge
    @(negedge clk);
    porta_in = 8'h05;
    repeat (2) @(negedge clk);
    check8("R10", "flag_a after 2 edges", flag_a, 8'h00);
    @(negedge clk);
    check8("R10", "flag_a after 3 edges", flag_a, 8'h05);
    @(negedge clk);
    model_step(8'h05, 8'h00, 1'b0, 1'b0);
    check_all("R2");
    check8("R2", "irq_a active low", {7'd0, irq_a}, 8'h00);

    // R5: second event recomputes flags, capture stays
    apply_in(8'h07, 8'h00);
    check_all("R5");
    check8("R5", "cap_a held", cap_a, 8'h05);

    // R6 clear port A
    pulse_clear(1'b1, 1'b0);
    check_all("R6");
    check8("R6", "irq_a inactive", {7'd0, irq_a}, 8'h01);

    // R3 compare mode
    cmp_mode_a = 8'hFF; defval_a = 8'h07;
    apply_in(8'h0F, 8'h00);
    check_all("R3");
    check8("R3", "flag_a mismatch bit3", flag_a, 8'h08);

    // R9 config alone changes nothing
    defval_a = 8'h00;
    repeat (4) @(negedge clk);
    check_all("R9");
    check8("R9", "flag_a unchanged", flag_a, 8'h08);

    // R4 masking by enable and direction
    pulse_clear(1'b1, 1'b1);
    cmp_mode_a = 8'h00; irq_en_a = 8'h0F; dir_a = 8'h3C;
    apply_in(8'hF0, 8'h00);
    check_all("R4");
    check8("R4", "flag_a masked", flag_a, 8'h0C);

    // R7 mirror mode
    pulse_clear(1'b1, 1'b1);
    mirror = 1'b1;
    apply_in(8'hF0, 8'h81);
    check_all("R7");
    check8("R7", "both irq active", {6'd0, irq_b, irq_a}, 8'h00);
    pulse_clear(1'b1, 1'b0);
    check_all("R7");
    check8("R7", "both irq inactive", {6'd0, irq_b, irq_a}, 8'h03);
    mirror = 1'b0;

    // R8 polarity
    pol_high = 1'b1;
    apply_in(8'hF0, 8'h80);
    check_all("R8");
    check8("R8", "irq_b active high", {7'd0, irq_b}, 8'h01);

    // R11 clear pulse coincides with an evaluation on port B
    @(negedge clk);
    portb_in = 8'h01;
    repeat (2) @(negedge clk);
    rd_clear_b = 1'b1;
    @(negedge clk);
    rd_clear_b = 1'b0;
    repeat (2) @(negedge clk);
    model_step(8'hF0, 8'h01, 1'b0, 1'b1);
    check_all("R11");
    check8("R11", "cap_b reloaded", cap_b, 8'h01);

    // constrained random
    dir_a = 8'hFF;
    for (int it = 0; it < 400; it++) begin
      int sel;
      sel = $urandom_range(0, 9);
      if (sel < 2) begin
        irq_en_a = $urandom; irq_en_b = $urandom;
        dir_a = $urandom | 8'hF0; dir_b = $urandom | 8'h0F;
        cmp_mode_a = $urandom; cmp_mode_b = $urandom;
        defval_a = $urandom; defval_b = $urandom;
        pol_high = $urandom_range(0, 1); mirror = $urandom_range(0, 1);
        repeat (2) @(negedge clk);
        check_all("R9");
      end else if (sel < 4) begin
        pulse_clear($urandom_range(0, 1), $urandom_range(0, 1));
        check_all("R6");
      end else begin
        logic [7:0] na, nb;
        na = m_prev_a ^ (8'(1) << $urandom_range(0, 7));
        nb = (sel == 9) ? 8'($urandom) : m_prev_b;
        apply_in(na, nb);
        check_all(mirror ? "R7" : "R2");
      end
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule